// File: doc/BRIEF.md
# Password Verifier with Retry Lockout

This block decides whether a host may touch a protected store. A host opens a session by naming a command class and a key slot, then streams the key bytes in, most significant byte first. The block compares them with the key held in the chosen slot and then enters a fixed-length write cycle. The outcome stays hidden until that cycle has ended. The host learns the outcome only by polling: it raises a poll strobe, and one cycle later the block answers with an acknowledge bit.

Every rejected key advances a failure counter. When the counter reaches its limit, the block asks for both data arrays to be erased. It then refuses every array key until a session with the reset key clears the condition. The stored keys themselves survive the lockout.

Keys are held in registers. A key can be replaced with a change command, and all keys can be wiped with the reset-key wipe command.

Top module: `pwlock_top`

## Requirements
- R1: There are five 64-bit key slots: 0 and 1 guard reads of arrays 0 and 1, 2 and 3 guard writes to arrays 0 and 1, and 4 holds the reset key. `cmdClass` is encoded as follows:
  - 0: array access, using slot `cmdSlot`.
  - 1: key change, using slot `cmdSlot`.
  - 2: device recovery, always using slot 4.
  - 3: key wipe, always using slot 4.
  A `cmdSlot` value above 4 never matches.
- R2: After reset every slot holds all zeros.
- R3: A key matches only when all of its bytes (8 for classes 0, 2 and 3; the first 8 of 16 for class 1) equal the stored bytes, sent most significant byte first. The mismatch is accumulated across every byte, so a wrong first byte and a wrong last byte are both rejected after the same full byte count.
- R4: A poll answers with `pollDone` one cycle after `pollStrobe`. `pollAck` is 0 while the write cycle of `BUSY_CYCLES` cycles is still running. After the cycle ends, `pollAck` is 1 only if the key matched.
- R5: Each rejected key, whatever class it belongs to, increments the failure count while the block is unlocked. Each accepted key returns the count to zero.
- R6: The `RETRY_LIMIT`-th consecutive rejection sets `locked` and pulses `clearArrays` for one cycle. The stored keys are not changed, and the count stops advancing.
- R7: While `locked` is set, slots 0 to 3 never match, even when the right key is sent.
- R8: A device recovery (class 2) with the correct reset key clears both `locked` and the count. It pulses neither clear output and leaves the keys unchanged.
- R9: A key wipe (class 3) with the correct reset key pulses `clearArrays` and `clearPasswords` together for one cycle and sets all five slots to zero.
- R10: A key change (class 1) takes 8 old-key bytes followed by 8 new-key bytes. If the old key matches, the slot takes the new key.
- R11: `grant` rises together with an acknowledging poll answer and falls when the next session is accepted.
- R12: While the write cycle is running, `cmdStart` and key bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdStart | input | 1 | Opens a session |
| cmdClass | input | 2 | Command class (R1 encoding) |
| cmdSlot | input | 3 | Key slot for classes 0 and 1 |
| byteValid | input | 1 | `byteIn` carries a key byte |
| byteIn | input | 8 | Key byte |
| pollStrobe | input | 1 | Requests the outcome |
| grant | output | 1 | Access granted |
| locked | output | 1 | Lockout active |
| clearArrays | output | 1 | One-cycle request to erase both arrays |
| clearPasswords | output | 1 | One-cycle pulse marking the key wipe |
| pollDone | output | 1 | Poll answer valid |
| pollAck | output | 1 | Poll answer: 1 = acknowledge |

## Verification
Several rules are checked by assertions on every cycle:
- the failure count stays within its limit;
- a lockout is always paired with an array-clear pulse;
- a key wipe is always paired with an array-clear pulse and leaves the slots at zero;
- an acknowledge never comes from a write cycle still in progress or from a session with a mismatch;
- a locked block never acknowledges an array slot;
- `grant` only rises with an acknowledge.

Other behaviour can only be shown by the bench's scenarios:
- the exact number of rejections that trips the lockout;
- keys surviving a lockout;
- key change and key wipe taking effect on later sessions;
- a session started during the write cycle being dropped.

// File: rtl/pwlock_pkg.sv
package pwlock_pkg;
  localparam int BYTE_W = 8;
  localparam int SLOT_W = 3;
  localparam int IDX_W  = 4;

  typedef enum logic [1:0] {
    CLS_ACCESS = 2'd0,
    CLS_CHANGE = 2'd1,
    CLS_RSTDEV = 2'd2,
    CLS_RSTPW  = 2'd3
  } cmdClass_e;

  typedef struct packed {
    logic             sessionStart;
    logic             cmpEn;
    logic             capEn;
    logic [IDX_W-1:0] byteIdx;
    logic             commitNew;
    logic             wipeAll;
  } dpStrobe_t;
endpackage

// File: rtl/pwlock_dp.sv
module pwlock_dp
  import pwlock_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int PW_BYTES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [SLOT_W-1:0] slotSel,
  input  logic [BYTE_W-1:0] byteIn,
  output logic              missAcc
);
  localparam int PW_W = PW_BYTES * BYTE_W;

  logic [PW_W-1:0]   store [NUM_SLOTS];
  logic [PW_W-1:0]   newPw;
  logic [PW_W-1:0]   selWord;
  logic              slotOk;
  logic [BYTE_W-1:0] refByte;
  logic              byteMiss;

  // Select the key word of the slot named by the session.
  always_comb begin
    selWord = '0;
    slotOk  = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slotSel == SLOT_W'(i)) begin
        selWord = store[i];
        slotOk  = 1'b1;
      end
    end
  end

  // Pick the reference byte; byte 0 is the most significant one.
  always_comb begin
    refByte = '0;
    for (int k = 0; k < PW_BYTES; k++) begin
      if (strb.byteIdx == IDX_W'(k)) refByte = selWord[(PW_BYTES-1-k)*BYTE_W +: BYTE_W];
    end
  end

  assign byteMiss = !slotOk || (refByte != byteIn);

  // Sticky mismatch: every byte is compared, with no early exit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  missAcc <= 1'b0;
    else if (strb.sessionStart) missAcc <= 1'b0;
    else if (strb.cmpEn)        missAcc <= missAcc | byteMiss;
  end

  // Shift register that collects the replacement key.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           newPw <= '0;
    else if (strb.capEn) newPw <= {newPw[PW_W-BYTE_W-1:0], byteIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) store[i] <= '0;
    end else if (strb.wipeAll) begin
      for (int i = 0; i < NUM_SLOTS; i++) store[i] <= '0;
    end else if (strb.commitNew) begin
      for (int i = 0; i < NUM_SLOTS; i++)
        if (slotSel == SLOT_W'(i)) store[i] <= newPw;
    end
  end

  AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.wipeAll |=> (store[0] == '0 && store[NUM_SLOTS-1] == '0)); // R9
  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (missAcc && !strb.sessionStart) |=> missAcc); // R3
endmodule

// File: rtl/pwlock_ctrl.sv
module pwlock_ctrl
  import pwlock_pkg::*;
#(
  parameter int PW_BYTES    = 8,
  parameter int RETRY_LIMIT = 8,
  parameter int BUSY_CYCLES = 1250000,
  parameter int RESET_SLOT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  cmdClass_e         cmdClass,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic              byteValid,
  input  logic              pollStrobe,
  input  logic              missAcc,
  output dpStrobe_t         strb,
  output logic [SLOT_W-1:0] slotSel,
  output logic              grant,
  output logic              locked,
  output logic              clearArrays,
  output logic              clearPasswords,
  output logic              pollDone,
  output logic              pollAck
);
  localparam int CNT_W = $clog2(2*PW_BYTES + 1);
  localparam int RT_W  = $clog2(RETRY_LIMIT + 1);
  localparam int TM_W  = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_EVAL, ST_BUSY} state_e;

  state_e     state;
  cmdClass_e  clsQ;
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] needLast;
  logic [RT_W-1:0]  retryCnt;
  logic [TM_W-1:0]  timer;
  logic resultValid, resultPass;
  logic accept, passNow, arraySlot, ackNow, byteTake;

  assign accept    = cmdStart && (state == ST_IDLE || state == ST_COLLECT);
  assign needLast  = (clsQ == CLS_CHANGE) ? CNT_W'(2*PW_BYTES - 1) : CNT_W'(PW_BYTES - 1);
  assign arraySlot = (slotSel != SLOT_W'(RESET_SLOT));
  assign passNow   = !missAcc && !(locked && arraySlot);
  assign byteTake  = (state == ST_COLLECT) && byteValid && !accept;
  assign ackNow    = pollStrobe && (state == ST_IDLE) && resultValid && resultPass;

  always_comb begin
    strb.sessionStart = accept;
    strb.cmpEn        = byteTake && (byteCnt < CNT_W'(PW_BYTES));
    strb.capEn        = byteTake && (byteCnt >= CNT_W'(PW_BYTES));
    strb.byteIdx      = IDX_W'(byteCnt);
    strb.commitNew    = (state == ST_EVAL) && (clsQ == CLS_CHANGE) && passNow;
    strb.wipeAll      = (state == ST_EVAL) && (clsQ == CLS_RSTPW) && passNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      clsQ           <= CLS_ACCESS;
      slotSel        <= '0;
      byteCnt        <= '0;
      retryCnt       <= '0;
      timer          <= '0;
      resultValid    <= 1'b0;
      resultPass     <= 1'b0;
      locked         <= 1'b0;
      clearArrays    <= 1'b0;
      clearPasswords <= 1'b0;
    end else begin
      clearArrays    <= 1'b0;
      clearPasswords <= 1'b0;
      if (accept) begin
        state       <= ST_COLLECT;
        clsQ        <= cmdClass;
        slotSel     <= (cmdClass == CLS_RSTDEV || cmdClass == CLS_RSTPW)
                       ? SLOT_W'(RESET_SLOT) : cmdSlot;
        byteCnt     <= '0;
        resultValid <= 1'b0;
      end else begin
        unique case (state)
          ST_COLLECT: if (byteValid) begin
            byteCnt <= byteCnt + 1'b1;
            if (byteCnt == needLast) state <= ST_EVAL;
          end
          ST_EVAL: begin
            resultPass  <= passNow;
            resultValid <= 1'b1;
            timer       <= TM_W'(BUSY_CYCLES - 1);
            state       <= ST_BUSY;
            if (passNow) begin
              retryCnt <= '0;
              if (clsQ == CLS_RSTDEV) locked <= 1'b0;
              if (clsQ == CLS_RSTPW) begin
                clearArrays    <= 1'b1;
                clearPasswords <= 1'b1;
              end
            end else if (!locked) begin
              if (retryCnt == RT_W'(RETRY_LIMIT - 1)) begin
                retryCnt    <= RT_W'(RETRY_LIMIT);
                locked      <= 1'b1;
                clearArrays <= 1'b1;
              end else begin
                retryCnt <= retryCnt + 1'b1;
              end
            end
          end
          ST_BUSY: begin
            if (timer == '0) state <= ST_IDLE;
            else             timer <= timer - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollDone <= 1'b0;
      pollAck  <= 1'b0;
      grant    <= 1'b0;
    end else begin
      pollDone <= pollStrobe;
      pollAck  <= ackNow;
      if (accept)      grant <= 1'b0;
      else if (ackNow) grant <= 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    retryCnt <= RT_W'(RETRY_LIMIT)); // R5
  AST_LOCK_WIPES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> clearArrays); // R6
  AST_LOCK_DENIES: assert property (@(posedge clk) disable iff (!rstN)
    (pollAck && locked) |-> (slotSel == SLOT_W'(RESET_SLOT))); // R7
  AST_ACK_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    pollAck |-> !missAcc); // R3
  AST_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    pollAck |-> ($past(state) != ST_BUSY)); // R4
  AST_WIPE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    clearPasswords |-> clearArrays); // R9
  AST_GRANT_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grant) |-> pollAck); // R11
endmodule

// File: rtl/pwlock_top.sv
module pwlock_top
  import pwlock_pkg::*;
#(
  parameter int NUM_SLOTS   = 5,
  parameter int PW_BYTES    = 8,
  parameter int RETRY_LIMIT = 8,
  parameter int BUSY_CYCLES = 1250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic [1:0] cmdClass,
  input  logic [2:0] cmdSlot,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  logic       pollStrobe,
  output logic       grant,
  output logic       locked,
  output logic       clearArrays,
  output logic       clearPasswords,
  output logic       pollDone,
  output logic       pollAck
);
  dpStrobe_t         strb;
  logic [SLOT_W-1:0] slotSel;
  logic              missAcc;

  pwlock_ctrl #(
    .PW_BYTES(PW_BYTES), .RETRY_LIMIT(RETRY_LIMIT),
    .BUSY_CYCLES(BUSY_CYCLES), .RESET_SLOT(NUM_SLOTS - 1)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdClass(cmdClass_e'(cmdClass)),
    .cmdSlot(cmdSlot), .byteValid(byteValid), .pollStrobe(pollStrobe),
    .missAcc(missAcc), .strb(strb), .slotSel(slotSel), .grant(grant),
    .locked(locked), .clearArrays(clearArrays), .clearPasswords(clearPasswords),
    .pollDone(pollDone), .pollAck(pollAck)
  );

  pwlock_dp #(.NUM_SLOTS(NUM_SLOTS), .PW_BYTES(PW_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .slotSel(slotSel),
    .byteIn(byteIn), .missAcc(missAcc)
  );
endmodule

// File: tb/pwlock_top_bench.sv
module pwlock_top_bench;
  localparam int BUSY = 16;
  localparam int LIMIT = 8;
  localparam logic [63:0] KEY_A = 64'h1122334455667788;
  localparam logic [63:0] KEY_B = 64'hCAFE0123BEEF4567;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdStart = 1'b0, byteValid = 1'b0, pollStrobe = 1'b0;
  logic [1:0] cmdClass = '0;
  logic [2:0] cmdSlot = '0;
  logic [7:0] byteIn = '0;
  logic grant, locked, clearArrays, clearPasswords, pollDone, pollAck;

  always #2 clk = ~clk;

  pwlock_top #(.RETRY_LIMIT(LIMIT), .BUSY_CYCLES(BUSY)) u_pwlock_top (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdClass(cmdClass),
    .cmdSlot(cmdSlot), .byteValid(byteValid), .byteIn(byteIn),
    .pollStrobe(pollStrobe), .grant(grant), .locked(locked),
    .clearArrays(clearArrays), .clearPasswords(clearPasswords),
    .pollDone(pollDone), .pollAck(pollAck)
  );

  int checks = 0, failures = 0;
  bit expAckQ[$];
  string tagQ[$];
  logic [63:0] pwM [5];
  int retryM = 0;
  bit lockM = 1'b0;
  int expArr = 0, expPw = 0, gotArr = 0, gotPw = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard for every poll answer.
  always @(negedge clk) begin
    if (rstN) begin
      if (clearArrays) gotArr++;
      if (clearPasswords) gotPw++;
      if (pollDone) begin
        if (expAckQ.size() == 0) check(1'b0, "R4 unexpected pollDone", 1, 0);
        else begin
          automatic bit e = expAckQ.pop_front();
          automatic string t = tagQ.pop_front();
          check(pollAck == e, t, pollAck, e);
        end
      end
    end
  end

  task automatic poll(input bit exp, input string tag);
    @(negedge clk);
    pollStrobe = 1'b1;
    expAckQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    pollStrobe = 1'b0;
  endtask

  // Driver: sends one session and, when modelled, predicts its outcome.
  task automatic session(input int cls, input int slot, input logic [63:0] oldK,
                         input logic [63:0] newK, input bit modelIt, output bit pass);
    int s;
    bit ok;
    @(negedge clk);
    cmdStart = 1'b1; cmdClass = 2'(cls); cmdSlot = 3'(slot);
    @(negedge clk);
    cmdStart = 1'b0;
    for (int k = 0; k < 8; k++) begin
      byteValid = 1'b1; byteIn = oldK[63-8*k -: 8];
      @(negedge clk);
    end
    if (cls == 1) for (int k = 0; k < 8; k++) begin
      byteValid = 1'b1; byteIn = newK[63-8*k -: 8];
      @(negedge clk);
    end
    byteValid = 1'b0;
    s = (cls >= 2) ? 4 : slot;
    ok = (s < 5) && (pwM[s] == oldK) && !(lockM && s != 4);
    pass = ok;
    if (modelIt) begin
      if (ok) begin
        retryM = 0;
        if (cls == 2) lockM = 1'b0;
        if (cls == 3) begin
          for (int i = 0; i < 5; i++) pwM[i] = '0;
          expArr++; expPw++;
        end
        if (cls == 1) pwM[s] = newK;
      end else if (!lockM) begin
        retryM++;
        if (retryM == LIMIT) begin lockM = 1'b1; expArr++; end
      end
    end
  endtask

  task automatic waitBusy();
    repeat (BUSY + 4) @(negedge clk);
  endtask

  task automatic full(input int cls, input int slot, input logic [63:0] oldK,
                      input logic [63:0] newK, input string tag);
    bit p;
    session(cls, slot, oldK, newK, 1'b1, p);
    waitBusy();
    poll(p, tag);
  endtask

  initial begin
    bit p, q;
    for (int i = 0; i < 5; i++) pwM[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(locked == 1'b0 && grant == 1'b0, "R2 reset flags", {locked, grant}, 0);
    check(clearArrays == 1'b0 && clearPasswords == 1'b0 && pollDone == 1'b0,
          "R2 reset pulses", {clearArrays, clearPasswords, pollDone}, 0);
    poll(1'b0, "R4 poll with no session");

    // R2/R3/R4: factory zero key in slot 0, early poll refused.
    session(0, 0, 64'h0, 64'h0, 1'b1, p);
    poll(1'b0, "R4 poll during write cycle");
    waitBusy();
    poll(p, "R2 zero key slot 0 accepted");
    check(grant == 1'b1, "R11 grant after ack", grant, 1);

    // R10: change slot 1, then old key rejected, new accepted.
    full(1, 1, 64'h0, KEY_A, "R10 change slot 1");
    full(0, 1, KEY_A, 64'h0, "R10 new key accepted");
    session(0, 1, 64'h0, 64'h0, 1'b1, p);
    check(grant == 1'b0, "R11 grant drops on new session", grant, 0);
    waitBusy();
    poll(p, "R10 old key rejected");

    // R3: wrong first byte, R12: session during write cycle ignored.
    session(0, 1, KEY_A ^ 64'h8000_0000_0000_0000, 64'h0, 1'b1, p);
    session(0, 1, KEY_A, 64'h0, 1'b0, q);
    waitBusy();
    poll(p, "R12 start during write cycle ignored");
    full(0, 1, KEY_A ^ 64'h1, 64'h0, "R3 wrong last byte");

    // R1: slot mapping.
    full(0, 3, 64'h0, 64'h0, "R1 slot 3 zero key");
    full(0, 5, 64'h0, 64'h0, "R1 slot above 4 rejected");

    // R5: correct key clears count, then LIMIT-1 rejections do not lock.
    full(0, 1, KEY_A, 64'h0, "R5 correct key resets count");
    for (int n = 0; n < LIMIT - 1; n++) full(0, 2, KEY_B, 64'h0, "R5 rejected key");
    check(locked == 1'b0, "R5 no lock below limit", locked, 0);
    check(gotArr == expArr, "R5 no clear below limit", gotArr, expArr);
    full(2, 0, KEY_B, 64'h0, "R6 limit-th rejection");
    check(locked == 1'b1, "R6 locked at limit", locked, 1);
    check(gotArr == expArr && gotPw == 0, "R6 arrays cleared once", gotArr, expArr);

    // R7: correct array key refused while locked.
    full(0, 1, KEY_A, 64'h0, "R7 locked refuses array key");
    full(2, 0, KEY_B, 64'h0, "R8 wrong reset key while locked");
    check(locked == 1'b1, "R8 still locked", locked, 1);

    // R8: recovery with correct reset key.
    full(2, 0, 64'h0, 64'h0, "R8 recovery accepted");
    check(locked == 1'b0, "R8 unlocked", locked, 0);
    check(gotArr == expArr && gotPw == expPw, "R8 no clears", gotArr, expArr);
    full(0, 1, KEY_A, 64'h0, "R6 key kept through lockout");

    // R9: set reset key, wipe, all keys back to zero.
    full(1, 4, 64'h0, KEY_B, "R10 change reset key");
    full(3, 0, KEY_B, 64'h0, "R9 wipe accepted");
    check(gotArr == expArr && gotPw == expPw, "R9 both clear pulses", {gotArr, gotPw}, {expArr, expPw});
    full(0, 1, KEY_A, 64'h0, "R9 old key gone");
    full(0, 1, 64'h0, 64'h0, "R9 slot 1 zero");
    full(2, 0, 64'h0, 64'h0, "R9 reset key zero");

    repeat (4) @(negedge clk);
    check(expAckQ.size() == 0, "R4 every poll answered", expAckQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R4 actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule